// File: doc/BRIEF.md
# Addressed Step-Attenuator Control Front End

This block is the digital control front end of a seven-bit step attenuator. It holds a registered attenuation code that drives the switch decoder. Each code step is 0.25 dB, so the range runs from 0 dB to 31.75 dB.

A mode pin selects how the code is loaded:

- **Serial mode.** A three-wire port (clock, data, latch enable) fills a sixteen-bit frame. The frame carries both the new code and a device address. A load is accepted only when the address matches three strap pins. This lets up to eight controllers share the same serial wires.
- **Parallel mode.** The code comes from seven pins. Either it follows them while latch enable is high, or it is captured when latch enable rises.

Every serial-port input and the mode pin are resampled by a two-flop synchronizer on a system clock. That clock runs at least four times faster than the serial clock. Edges are detected on the resampled signals, so the code register changes only on system clock edges. Reset forces maximum attenuation.

Top module: `atten_ctrl`

## Requirements
- R1: During and after reset, `atten_code` is 0x7F (maximum attenuation) in either mode. In parallel mode with latch enable low, it stays 0x7F until latch enable rises.
- R2: In serial mode, each rising `ser_clk` edge shifts `ser_data` into a 16-bit frame while `latch_en` is low. The frame is filled LSB first: the first bit shifted ends in frame bit 0, the first 8 bits form the attenuation word (frame bits 7..0) and the last 8 form the address word (frame bits 15..8). When `latch_en` rises and frame bits 10..8 equal `addr_strap`, `atten_code` takes frame bits 6..0.
- R3: On a `latch_en` rise in serial mode whose frame bits 10..8 differ from `addr_strap`, `atten_code` keeps its value.
- R4: Frame bits 15..11 play no part in the address match, and frame bit 7 never reaches `atten_code`.
- R5: While `latch_en` is high, `ser_clk` edges do not change the frame.
- R6: `mode_ser` high selects serial mode, and in serial mode `par_code` has no effect. `mode_ser` low selects parallel mode.
- R7: In parallel mode with the synchronized latch enable high, `atten_code` equals `par_code` one system clock later.
- R8: In parallel mode with latch enable low, changes on `par_code` have no effect. The value present when latch enable rises is captured.
- R9: A serial load becomes visible at `atten_code` on the third system clock edge after `latch_en` rises at the pin. That is two synchronizer stages plus one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low reset, loads maximum attenuation |
| mode_ser | input | 1 | 1 selects serial control, 0 selects parallel control |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, LSB first |
| latch_en | input | 1 | Latch enable: freezes shifting when high, rising edge applies a frame or captures parallel pins |
| addr_strap | input | 3 | Strapped device address |
| par_code | input | 7 | Parallel attenuation code, bit k worth 0.25·2^k dB |
| atten_code | output | 7 | Active attenuation code to the switch decoder |

## Verification
The hardest case to reach is showing that clocking with latch enable high really leaves the frame untouched. The frame itself is not visible at the ports, so the test works through the address match. First a frame addressed to another device is loaded and rejected. Then a second frame, carrying a different address and code, is clocked in with latch enable held high. Finally the straps are moved to the first frame's address and latch enable is pulsed with no clock edges in between. The first frame's code appears only if the second frame was never shifted in. Exact-cycle sampling after a latch enable rise also pins down the synchronizer latency.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W_DEF = 7;
  localparam int ADDR_W_DEF = 3;
  localparam int WORD_W_DEF = 8;

  typedef enum logic {
    CTL_PARALLEL = 1'b0,
    CTL_SERIAL   = 1'b1
  } ctl_mode_e;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], pin};
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter #(
  parameter int WORD_W = 8,
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_lvl,
  input  logic              sdata_lvl,
  input  logic              le_lvl,
  output logic [CODE_W-1:0] code_field,
  output logic [ADDR_W-1:0] addr_field,
  output logic              shift_evt
);
  localparam int FRAME_W = 2 * WORD_W;

  function automatic logic [FRAME_W-1:0] reset_frame();
    return {{WORD_W{1'b0}}, {(WORD_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};
  endfunction

  logic               sclk_prev;
  logic [FRAME_W-1:0] frame_q;

  assign shift_evt = sclk_lvl & ~sclk_prev & ~le_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      frame_q   <= reset_frame();
    end else begin
      sclk_prev <= sclk_lvl;
      if (shift_evt) frame_q <= {sdata_lvl, frame_q[FRAME_W-1:1]};
    end
  end

  assign code_field = frame_q[CODE_W-1:0];
  assign addr_field = frame_q[WORD_W +: ADDR_W];

  AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    le_lvl |=> $stable(frame_q)); // R5
endmodule

// File: rtl/atten_codereg.sv
module atten_codereg
  import atten_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_lvl,
  input  logic              le_lvl,
  input  logic [ADDR_W-1:0] addr_rx,
  input  logic [ADDR_W-1:0] strap,
  input  logic [CODE_W-1:0] code_rx,
  input  logic [CODE_W-1:0] par_code,
  output logic [CODE_W-1:0] code_q
);
  function automatic logic addr_match(logic [ADDR_W-1:0] rx, logic [ADDR_W-1:0] st);
    return rx == st;
  endfunction

  logic le_prev;
  logic le_rise;
  logic is_serial;
  logic ser_load;
  logic ser_reject;
  logic par_follow;

  assign is_serial  = (ctl_mode_e'(mode_lvl) == CTL_SERIAL);
  assign le_rise    = le_lvl & ~le_prev;
  assign ser_load   = is_serial & le_rise & addr_match(addr_rx, strap);
  assign ser_reject = is_serial & le_rise & ~addr_match(addr_rx, strap);
  assign par_follow = ~is_serial & le_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_prev <= 1'b1;
      code_q  <= {CODE_W{1'b1}};
    end else begin
      le_prev <= le_lvl;
      if (ser_load)        code_q <= code_rx;
      else if (par_follow) code_q <= par_code;
    end
  end

  AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |=> code_q == $past(code_rx)); // R2
  AST_ADDR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_reject |=> $stable(code_q)); // R3
  AST_SER_IGNORES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_serial && !le_rise) |=> $stable(code_q)); // R6
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    par_follow |=> code_q == $past(par_code)); // R7
  AST_LE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !le_lvl |=> $stable(code_q)); // R8
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl #(
  parameter int CODE_W      = atten_pkg::CODE_W_DEF,
  parameter int ADDR_W      = atten_pkg::ADDR_W_DEF,
  parameter int WORD_W      = atten_pkg::WORD_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ser,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              latch_en,
  input  logic [ADDR_W-1:0] addr_strap,
  input  logic [CODE_W-1:0] par_code,
  output logic [CODE_W-1:0] atten_code
);
  localparam int         N_SYNC   = 4;
  localparam logic [3:0] SYNC_RST = 4'b1110; // mode, le, sclk idle high; data low

  logic [N_SYNC-1:0] pin_raw;
  logic [N_SYNC-1:0] pin_lvl;

  assign pin_raw = {mode_ser, latch_en, ser_clk, ser_data};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    atten_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_raw[g]), .lvl(pin_lvl[g])
    );
  end

  logic              mode_lvl, le_lvl, sclk_lvl, sdata_lvl;
  logic [CODE_W-1:0] code_field;
  logic [ADDR_W-1:0] addr_field;
  logic              shift_evt;

  assign {mode_lvl, le_lvl, sclk_lvl, sdata_lvl} = pin_lvl;

  atten_shifter #(.WORD_W(WORD_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl), .sdata_lvl(sdata_lvl),
    .le_lvl(le_lvl), .code_field(code_field), .addr_field(addr_field),
    .shift_evt(shift_evt)
  );

  atten_codereg #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_code (
    .clk(clk), .rst_n(rst_n), .mode_lvl(mode_lvl), .le_lvl(le_lvl),
    .addr_rx(addr_field), .strap(addr_strap), .code_rx(code_field),
    .par_code(par_code), .code_q(atten_code)
  );

  AST_SHIFT_NEEDS_SERIAL_LE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> !le_lvl); // R5
endmodule

// File: tb/tb_atten_ctrl.sv
module tb_atten_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_ser, ser_clk, ser_data, latch_en;
  logic [2:0] addr_strap;
  logic [6:0] par_code;
  logic [6:0] atten_code;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  atten_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .ser_clk(ser_clk),
    .ser_data(ser_data), .latch_en(latch_en), .addr_strap(addr_strap),
    .par_code(par_code), .atten_code(atten_code)
  );

  // {strap[2:0], frame[15:0], expected code[6:0]}
  localparam logic [25:0] VEC [0:6] = '{
    {3'd0, 16'h0015, 7'h15},  // R2 match
    {3'd0, 16'h0122, 7'h15},  // R3 wrong address
    {3'd3, 16'hFBAA, 7'h2A},  // R4 high addr bits, bit 7 set
    {3'd7, 16'h0700, 7'h00},  // R2 minimum
    {3'd7, 16'h067F, 7'h00},  // R3
    {3'd5, 16'hE5FF, 7'h7F},  // R4
    {3'd2, 16'h0240, 7'h40}   // R2
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    n_cmp++;
    if (atten_code !== exp) begin
      n_bad++;
      $display("FAIL %s: atten_code=%h expected=%h", req, atten_code, exp);
    end
  endtask

  task automatic clock_bits(input logic [15:0] frame);
    for (int i = 0; i < 16; i++) begin
      ser_data = frame[i];
      tick(2);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(2);
    end
  endtask

  task automatic send_frame(input logic [15:0] frame);
    latch_en = 1'b0;
    tick(3);
    clock_bits(frame);
  endtask

  task automatic pulse_latch();
    latch_en = 1'b1;
    tick(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_ser = 1'b1; ser_clk = 1'b0; ser_data = 1'b0;
    latch_en = 1'b1; addr_strap = 3'd0; par_code = 7'h00;
    tick(3);
    check("R1 during reset", 7'h7F);
    rst_n = 1'b1;
    tick(6);
    check("R1 after reset serial", 7'h7F);

    for (int i = 0; i < 7; i++) begin
      addr_strap = VEC[i][25:23];
      send_frame(VEC[i][22:7]);
      pulse_latch();
      check("R2/R3/R4 vector", VEC[i][6:0]);
    end

    // R9 latency: old value after two edges, new value after the third
    addr_strap = 3'd1;
    send_frame(16'h0133);
    latch_en = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 before third edge", 7'h40);
    @(negedge clk);
    check("R9 on third edge", 7'h33);
    tick(4);

    // R5 frozen shifting while latch enable is high
    addr_strap = 3'd0;
    send_frame(16'h0511);
    pulse_latch();
    check("R3 addr 5 vs strap 0", 7'h33);
    clock_bits(16'h0066);
    addr_strap = 3'd5;
    latch_en = 1'b0;
    tick(4);
    pulse_latch();
    check("R5 frame kept while LE high", 7'h11);

    // R6 serial mode ignores parallel pins, then switch to parallel
    par_code = 7'h0C;
    tick(6);
    check("R6 pins ignored in serial", 7'h11);
    mode_ser = 1'b0;
    tick(6);
    check("R6/R7 parallel transparent", 7'h0C);
    par_code = 7'h55;
    @(negedge clk);
    check("R7 one-cycle follow", 7'h55);

    // R8 latched parallel
    latch_en = 1'b0;
    tick(6);
    par_code = 7'h3C;
    tick(6);
    check("R8 pins ignored while LE low", 7'h55);
    pulse_latch();
    check("R8 captured on LE rise", 7'h3C);

    // R1 reset in latched parallel mode
    latch_en = 1'b0;
    rst_n = 1'b0;
    tick(3);
    check("R1 reset in parallel", 7'h7F);
    rst_n = 1'b1;
    par_code = 7'h01;
    tick(6);
    check("R1/R8 default held with LE low", 7'h7F);
    pulse_latch();
    check("R8 capture after reset", 7'h01);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule